// File: doc/BRIEF.md
# Legacy PC System Control Ports

This block collects the small I/O-port-mapped control functions that a PC-compatible platform expects near its CPU. It watches a simple I/O bus made of an address, a write data value, a write strobe and a combinational read data return. From that bus it drives the address-line-20 gate, latches the math-coprocessor error interrupt until software acknowledges it, swallows POST-delay writes, streams debug characters from the boot firmware and the video firmware, records panic codes from either firmware, and raises a power-off request.

The power-off request needs a fixed eight-character ASCII key written one byte at a time to a single port. Any wrong byte silently restarts the match. All state changes are registered, so each takes effect on the clock edge that samples the write. Reads are decoded combinationally from the address alone.

Top module: `legacy_sysctl`

## Requirements
- R1: After reset, a20_en is 1 and ferr_irq, shutdown_req, dbg_valid, fw_panic and vid_panic are 0. Both panic codes are 0.
- R2: A write to port 0x0092 loads a20_en from data bit 1 on the next clock edge. Data bit 0 (the fast-reset bit) and the other bits have no effect.
- R3: When io_addr is 0x0092, io_rdata is a20_en in bit 1 and zero in every other bit. For any other address, io_rdata is all ones.
- R4: fpu_err high at a clock edge sets ferr_irq. ferr_irq then stays high until a write to port 0x00F0, with any data, clears it. If fpu_err and that write fall in the same cycle, the set wins.
- R5: A write to port 0x0080 is discarded and changes no output.
- R6: Byte writes (data bits 7:0) to port 0x8900 carrying 0x53,0x68,0x75,0x74,0x64,0x6F,0x77,0x6E ("Shutdown") in that order produce a one-cycle shutdown_req pulse in the cycle after the eighth write. The match then restarts from the first character, so the key can fire again.
- R7: A byte to port 0x8900 that does not equal the expected character sets the match back to the first character. That byte is not itself compared with the first character.
- R8: A write to port 0x0400 or 0x0401 sets the sticky fw_panic flag and loads fw_panic_code with the 16-bit write data. A write to port 0x0501 or 0x0502 does the same for vid_panic and vid_panic_code. The flags clear only on reset.
- R9: A write to port 0x0402 or 0x0403 gives a one-cycle dbg_valid with dbg_char equal to data bits 7:0 and dbg_src 0. Ports 0x0500 and 0x0503 do the same with dbg_src 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 16 | I/O port address |
| io_wdata | input | 16 | Write data |
| io_wr | input | 1 | Write strobe, one write per cycle |
| io_rdata | output | 16 | Read data for io_addr |
| fpu_err | input | 1 | Math-coprocessor error indication from the CPU |
| a20_en | output | 1 | Address line 20 enable |
| ferr_irq | output | 1 | Coprocessor error interrupt level, routed to ISA IRQ 13 |
| shutdown_req | output | 1 | One-cycle power-off request |
| dbg_valid | output | 1 | Debug character strobe |
| dbg_char | output | 8 | Debug character |
| dbg_src | output | 1 | 0 = boot firmware, 1 = video firmware |
| fw_panic | output | 1 | Boot firmware panic flag (sticky) |
| fw_panic_code | output | 16 | Last boot firmware panic code |
| vid_panic | output | 1 | Video firmware panic flag (sticky) |
| vid_panic_code | output | 16 | Last video firmware panic code |

## Verification
Every registered result (a20_en, ferr_irq, shutdown_req, the debug strobe and the panic flags) is due exactly one edge after the edge that samples the write or fpu_err. io_rdata follows io_addr in the same cycle. The bench drives inputs on the falling edge and reads outputs on the following falling edge, half a cycle after the edge that loads them. It then looks one more falling edge later to confirm that the pulses last a single cycle.

// File: rtl/legacy_sysctl_pkg.sv
package legacy_sysctl_pkg;

  localparam logic [15:0] PORT_A20      = 16'h0092;
  localparam logic [15:0] PORT_FERR_ACK = 16'h00F0;
  localparam logic [15:0] PORT_POST     = 16'h0080;
  localparam logic [15:0] PORT_KEY      = 16'h8900;
  localparam logic [15:0] PORT_FWPAN_A  = 16'h0400;
  localparam logic [15:0] PORT_FWPAN_B  = 16'h0401;
  localparam logic [15:0] PORT_FWDBG_A  = 16'h0402;
  localparam logic [15:0] PORT_FWDBG_B  = 16'h0403;
  localparam logic [15:0] PORT_VDDBG_A  = 16'h0500;
  localparam logic [15:0] PORT_VDPAN_A  = 16'h0501;
  localparam logic [15:0] PORT_VDPAN_B  = 16'h0502;
  localparam logic [15:0] PORT_VDDBG_B  = 16'h0503;

  localparam int KEY_LEN = 8;
  localparam int KEY_IW  = $clog2(KEY_LEN);
  localparam int NGRP    = 2;

  typedef struct packed {
    logic            a20;
    logic            ferr_ack;
    logic            post;
    logic            key;
    logic [NGRP-1:0] panic;
    logic [NGRP-1:0] dbg;
  } hits_t;

  function automatic logic [7:0] key_char(input logic [KEY_IW-1:0] idx);
    logic [7:0] c;
    case (idx)
      3'd0:    c = 8'h53;
      3'd1:    c = 8'h68;
      3'd2:    c = 8'h75;
      3'd3:    c = 8'h74;
      3'd4:    c = 8'h64;
      3'd5:    c = 8'h6F;
      3'd6:    c = 8'h77;
      default: c = 8'h6E;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/lsc_decode.sv
module lsc_decode
  import legacy_sysctl_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          wr,
  input  logic [AW-1:0] addr,
  output hits_t         hits,
  output logic          rd_a20
);

  function automatic logic at(input logic [AW-1:0] a, input logic [15:0] p);
    return a == AW'(p);
  endfunction

  always_comb begin
    hits          = '0;
    hits.a20      = wr && at(addr, PORT_A20);
    hits.ferr_ack = wr && at(addr, PORT_FERR_ACK);
    hits.post     = wr && at(addr, PORT_POST);
    hits.key      = wr && at(addr, PORT_KEY);
    hits.panic[0] = wr && (at(addr, PORT_FWPAN_A) || at(addr, PORT_FWPAN_B));
    hits.panic[1] = wr && (at(addr, PORT_VDPAN_A) || at(addr, PORT_VDPAN_B));
    hits.dbg[0]   = wr && (at(addr, PORT_FWDBG_A) || at(addr, PORT_FWDBG_B));
    hits.dbg[1]   = wr && (at(addr, PORT_VDDBG_A) || at(addr, PORT_VDDBG_B));
    rd_a20        = at(addr, PORT_A20);
  end

endmodule

// File: rtl/lsc_key_match.sv
module lsc_key_match
  import legacy_sysctl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       step,
  input  logic [7:0] byte_in,
  output logic       evt_match,
  output logic       evt_done,
  output logic       fire
);

  logic [KEY_IW-1:0] idx_q;

  always_comb begin
    evt_match = step && (byte_in == key_char(idx_q));
    evt_done  = evt_match && (idx_q == KEY_IW'(KEY_LEN - 1));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q <= '0;
      fire  <= 1'b0;
    end else begin
      fire <= evt_done;
      if (step) begin
        if (evt_match && !evt_done) idx_q <= idx_q + 1'b1;
        else                        idx_q <= '0;
      end
    end
  end

endmodule

// File: rtl/lsc_panic_reg.sv
module lsc_panic_reg #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hit,
  input  logic [DW-1:0] data,
  output logic          flag,
  output logic [DW-1:0] code
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag <= 1'b0;
      code <= '0;
    end else if (hit) begin
      flag <= 1'b1;
      code <= data;
    end
  end

endmodule

// File: rtl/legacy_sysctl.sv
module legacy_sysctl
  import legacy_sysctl_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] io_addr,
  input  logic [DW-1:0] io_wdata,
  input  logic          io_wr,
  output logic [DW-1:0] io_rdata,
  input  logic          fpu_err,
  output logic          a20_en,
  output logic          ferr_irq,
  output logic          shutdown_req,
  output logic          dbg_valid,
  output logic [CW-1:0] dbg_char,
  output logic          dbg_src,
  output logic          fw_panic,
  output logic [DW-1:0] fw_panic_code,
  output logic          vid_panic,
  output logic [DW-1:0] vid_panic_code
);

  localparam int A20_BIT = 1;

  hits_t         hits;
  logic          rd_a20;
  logic          evt_key_match;
  logic          evt_key_done;
  logic          evt_ferr_ack;
  logic          evt_dbg;
  logic [NGRP-1:0] pan_flag;
  logic [DW-1:0] pan_code [NGRP];

  lsc_decode #(.AW(AW)) u_dec (
    .wr     (io_wr),
    .addr   (io_addr),
    .hits   (hits),
    .rd_a20 (rd_a20)
  );

  lsc_key_match u_key (
    .clk       (clk),
    .rst_n     (rst_n),
    .step      (hits.key),
    .byte_in   (io_wdata[7:0]),
    .evt_match (evt_key_match),
    .evt_done  (evt_key_done),
    .fire      (shutdown_req)
  );

  for (genvar g = 0; g < NGRP; g++) begin : g_pan
    lsc_panic_reg #(.DW(DW)) u_pan (
      .clk   (clk),
      .rst_n (rst_n),
      .hit   (hits.panic[g]),
      .data  (io_wdata),
      .flag  (pan_flag[g]),
      .code  (pan_code[g])
    );
  end

  assign fw_panic       = pan_flag[0];
  assign fw_panic_code  = pan_code[0];
  assign vid_panic      = pan_flag[1];
  assign vid_panic_code = pan_code[1];

  assign evt_ferr_ack = hits.ferr_ack;
  assign evt_dbg      = |hits.dbg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a20_en    <= 1'b1;
      ferr_irq  <= 1'b0;
      dbg_valid <= 1'b0;
      dbg_char  <= '0;
      dbg_src   <= 1'b0;
    end else begin
      if (hits.a20) a20_en <= io_wdata[A20_BIT];
      if (fpu_err)           ferr_irq <= 1'b1;
      else if (evt_ferr_ack) ferr_irq <= 1'b0;
      dbg_valid <= evt_dbg;
      if (evt_dbg) begin
        dbg_char <= io_wdata[CW-1:0];
        dbg_src  <= hits.dbg[1];
      end
    end
  end

  always_comb begin
    io_rdata = '1;
    if (rd_a20) begin
      io_rdata          = '0;
      io_rdata[A20_BIT] = a20_en;
    end
  end

endmodule

// File: rtl/legacy_sysctl_chk.sv
module legacy_sysctl_chk #(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] io_addr,
  input logic [DW-1:0] io_wdata,
  input logic          io_wr,
  input logic [DW-1:0] io_rdata,
  input logic          fpu_err,
  input logic          a20_en,
  input logic          ferr_irq,
  input logic          shutdown_req,
  input logic          dbg_valid,
  input logic          fw_panic,
  input logic          vid_panic,
  input logic          evt_key_done,
  input logic          evt_ferr_ack
);

  AST_A20_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(io_wr && io_addr == AW'(16'h0092)) |=> $stable(a20_en)); // R2

  AST_RD_OTHER: assert property (@(posedge clk) disable iff (!rst_n)
    io_addr != AW'(16'h0092) |-> io_rdata == '1); // R3

  AST_FERR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    fpu_err |=> ferr_irq); // R4

  AST_FERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ferr_irq && !evt_ferr_ack) |=> ferr_irq); // R4

  AST_SHUT_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    evt_key_done |-> (io_wr && io_addr == AW'(16'h8900) && io_wdata[7:0] == 8'h6E)); // R6

  AST_SHUT_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown_req |=> !shutdown_req); // R6

  AST_PANIC_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (fw_panic |=> fw_panic) and (vid_panic |=> vid_panic)); // R8

  AST_DBG_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_valid |-> $past(io_wr)); // R9

endmodule

bind legacy_sysctl legacy_sysctl_chk #(.AW(AW), .DW(DW)) i_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .io_addr      (io_addr),
  .io_wdata     (io_wdata),
  .io_wr        (io_wr),
  .io_rdata     (io_rdata),
  .fpu_err      (fpu_err),
  .a20_en       (a20_en),
  .ferr_irq     (ferr_irq),
  .shutdown_req (shutdown_req),
  .dbg_valid    (dbg_valid),
  .fw_panic     (fw_panic),
  .vid_panic    (vid_panic),
  .evt_key_done (evt_key_done),
  .evt_ferr_ack (evt_ferr_ack)
);

// File: tb/test_legacy_sysctl.sv
module test_legacy_sysctl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] io_addr = '0;
  logic [15:0] io_wdata = '0;
  logic        io_wr = 1'b0;
  logic [15:0] io_rdata;
  logic        fpu_err = 1'b0;
  logic        a20_en, ferr_irq, shutdown_req, dbg_valid, dbg_src;
  logic [7:0]  dbg_char;
  logic        fw_panic, vid_panic;
  logic [15:0] fw_panic_code, vid_panic_code;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  legacy_sysctl i_legacy_sysctl (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wdata(io_wdata),
    .io_wr(io_wr), .io_rdata(io_rdata), .fpu_err(fpu_err), .a20_en(a20_en),
    .ferr_irq(ferr_irq), .shutdown_req(shutdown_req), .dbg_valid(dbg_valid),
    .dbg_char(dbg_char), .dbg_src(dbg_src), .fw_panic(fw_panic),
    .fw_panic_code(fw_panic_code), .vid_panic(vid_panic),
    .vid_panic_code(vid_panic_code)
  );

  // {addr, data, expected a20_en, expected dbg_valid}
  localparam int NV = 7;
  localparam logic [33:0] VEC [NV] = '{
    {16'h0092, 16'h0000, 1'b0, 1'b0},
    {16'h0092, 16'h0003, 1'b1, 1'b0},
    {16'h0080, 16'h00FF, 1'b1, 1'b0},
    {16'h0092, 16'h0001, 1'b0, 1'b0},
    {16'h0402, 16'h0041, 1'b0, 1'b1},
    {16'h0080, 16'h0002, 1'b0, 1'b0},
    {16'h0092, 16'hFFFD, 1'b0, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drives a write for one cycle; returns half a cycle after the loading edge
  task automatic wr(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0; io_addr = 16'h0000;
  endtask

  task automatic send_str(input logic [7:0] s [], output int pulses);
    pulses = 0;
    foreach (s[i]) begin
      wr(16'h8900, {8'h00, s[i]});
      if (shutdown_req) pulses++;
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] key [] = '{8'h53, 8'h68, 8'h75, 8'h74, 8'h64, 8'h6F, 8'h77, 8'h6E};
    logic [7:0] bad [] = '{8'h53, 8'h68, 8'h53, 8'h68, 8'h75, 8'h74, 8'h64, 8'h6F, 8'h77, 8'h6E};
    int p;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 a20", a20_en, 1);
    check("R1 ferr", ferr_irq, 0);
    check("R1 flags", {shutdown_req, dbg_valid, fw_panic, vid_panic}, 0);
    check("R1 codes", {fw_panic_code, vid_panic_code}, 0);

    // R2 R5 R9 vector table
    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][33:18], VEC[i][17:2]);
      check("R2 R5 a20 vector", a20_en, VEC[i][1]);
      check("R9 dbg strobe vector", dbg_valid, VEC[i][0]);
    end

    // R3 reads
    io_addr = 16'h0092; #1;
    check("R3 read a20=0", io_rdata, 16'h0000);
    wr(16'h0092, 16'h0002);
    io_addr = 16'h0092; #1;
    check("R3 read a20=1", io_rdata, 16'h0002);
    io_addr = 16'h0093; #1;
    check("R3 unmapped", io_rdata, 16'hFFFF);
    io_addr = 16'h0000;

    // R4 ferr
    @(negedge clk); fpu_err = 1'b1;
    @(negedge clk); fpu_err = 1'b0;
    check("R4 ferr set", ferr_irq, 1);
    repeat (3) @(negedge clk);
    check("R4 ferr held", ferr_irq, 1);
    wr(16'h0080, 16'h0000);
    check("R5 post ignored ferr", ferr_irq, 1);
    wr(16'h00F0, 16'h1234);
    check("R4 ferr cleared", ferr_irq, 0);
    @(negedge clk);
    io_addr = 16'h00F0; io_wr = 1'b1; fpu_err = 1'b1;
    @(negedge clk);
    io_wr = 1'b0; fpu_err = 1'b0;
    check("R4 set wins", ferr_irq, 1);
    wr(16'h00F0, 16'h0000);

    // R9 debug characters
    wr(16'h0403, 16'hAB5A);
    check("R9 fw char", {dbg_valid, dbg_src, dbg_char}, {2'b10, 8'h5A});
    @(negedge clk);
    check("R9 strobe one cycle", dbg_valid, 0);
    wr(16'h0500, 16'h0031);
    check("R9 vid char a", {dbg_valid, dbg_src, dbg_char}, {2'b11, 8'h31});
    wr(16'h0503, 16'h0032);
    check("R9 vid char b", {dbg_valid, dbg_src, dbg_char}, {2'b11, 8'h32});

    // R6 shutdown key
    send_str(key, p);
    check("R6 pulse on last byte", p, 1);
    check("R6 pulse is last cycle", shutdown_req, 1);
    @(negedge clk);
    check("R6 pulse width", shutdown_req, 0);
    send_str(key, p);
    check("R6 fires again", p, 1);

    // R7 wrong byte not retested
    send_str(bad, p);
    check("R7 no fire after mismatch", p, 0);
    wr(16'h8900, 16'h0041);
    send_str(key, p);
    check("R7 recover after wrong byte", p, 1);

    // R8 panic flags
    check("R8 clean before", {fw_panic, vid_panic}, 0);
    wr(16'h0401, 16'h01C3);
    check("R8 fw panic", {fw_panic, fw_panic_code}, {1'b1, 16'h01C3});
    check("R8 vid untouched", vid_panic, 0);
    wr(16'h0502, 16'h0777);
    check("R8 vid panic", {vid_panic, vid_panic_code}, {1'b1, 16'h0777});
    repeat (4) @(negedge clk);
    check("R8 sticky", {fw_panic, vid_panic}, 2'b11);

    // R1 reset again
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    check("R1 reset clears", {fw_panic, vid_panic, a20_en}, 3'b001);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule